// File: doc/BRIEF.md
# Complex Baseband FM Discriminator

This block estimates the instantaneous frequency of a frequency-modulated signal that has already been shifted down to complex baseband and lowpass filtered. For each accepted I/Q sample it forms the cross-product of each component with the one-sample backward difference of the other component: I times the change in Q, minus Q times the change in I. Because an FM waveform has a constant envelope, the block does not normalise by the envelope power. It uses neither an arctangent nor a divider.

A typical use places it after a complex down-mixer and a low-order IIR lowpass filter. The mixer multiplies the real input by cos(θ) − j·sin(θ). The output is then a sampled copy of the message, for example a 1 kHz tone carried with roughly 1.5 to 2 kHz of peak deviation at a 96 kHz sample rate. The arithmetic is exact: the differences are one bit wider than the inputs, the products keep full precision, and the result is 2·W+2 bits wide, so nothing saturates or wraps.

The block keeps a history of the previous I and Q sample, and reset clears it to zero. The first result after reset is therefore a start-up transient and is flagged as such.

Top module: `fm_discrim`

## Requirements
- R1: While reset is asserted, and after it is released until the first result, `out_valid` and `out_first` are 0 and `out_value` is 0.
- R2: Each cycle in which `in_valid` is 1 produces exactly one cycle with `out_valid` = 1, two clock cycles later. `out_valid` is 0 in every other cycle.
- R3: For accepted sample n, `out_value` equals I[n]·(Q[n]−Q[n−1]) − Q[n]·(I[n]−I[n−1]), where [n−1] is the previous accepted sample. The value is an exact two's-complement number of 2·W+2 bits.
- R4: Reset clears the stored previous sample to zero, so the first result after reset is exactly 0.
- R5: `out_first` is 1 together with the first `out_valid` after reset and is 0 on every later result.
- R6: Input words presented while `in_valid` is 0 are ignored. They neither change the stored history nor produce a result, so the next accepted sample is differenced against the last accepted one.
- R7: Full-scale inputs, including the most negative code on I and Q and steps from −2^(W−1) to 2^(W−1)−1, give the exact result without overflow.
- R8: `out_value` holds its last result in every cycle in which `out_valid` is 0.
- R9: Samples accepted in consecutive cycles give consecutive results with the same two-cycle latency and with no sample lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Sample strobe for in_i and in_q |
| in_i | input | W | Signed in-phase sample |
| in_q | input | W | Signed quadrature sample |
| out_valid | output | 1 | Result strobe, two cycles after in_valid |
| out_first | output | 1 | Marks the start-up result after reset |
| out_value | output | 2·W+2 | Signed discriminator result |

## Verification
The assertions assume that `in_valid` is a known 0 or 1 on every clock edge once the internal reset has been released. They also assume that the sample words are meaningful only in cycles where the strobe is high. The stimulus changes inputs only on the falling clock edge and waits out the reset synchronizer before the first strobe. It places unrelated words on the data lines while the strobe is low, so the history and hold behaviour are exercised without breaking those assumptions. The data cover a rotating phasor, full-scale corners and back-to-back strobes.

// File: rtl/fmd_pkg.sv
package fmd_pkg;
  localparam int unsigned DIFF_EXTRA = 1;
  localparam int unsigned OUT_EXTRA  = 2;
  localparam int unsigned SYNC_DEPTH = 2;
endpackage

// File: rtl/fmd_rst_sync.sv
module fmd_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_s_n = sync_q[STAGES-1];
endmodule

// File: rtl/fmd_diff_stage.sv
module fmd_diff_stage #(
  parameter int unsigned W = 16,
  localparam int unsigned DW = W + fmd_pkg::DIFF_EXTRA
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic signed [W-1:0]  smp_i,
  input  logic signed [W-1:0]  smp_q,
  output logic                 s1_valid,
  output logic                 s1_first,
  output logic signed [W-1:0]  s1_i,
  output logic signed [W-1:0]  s1_q,
  output logic signed [DW-1:0] s1_di,
  output logic signed [DW-1:0] s1_dq
);
  logic signed [W-1:0]  hist_i_q, hist_i_d;
  logic signed [W-1:0]  hist_q_q, hist_q_d;
  logic                 seen_q, seen_d;
  logic signed [W-1:0]  cur_i_q, cur_i_d, cur_q_q, cur_q_d;
  logic signed [DW-1:0] di_q, di_d, dq_q, dq_d;
  logic                 vld_q, vld_d, first_q, first_d;

  always_comb begin
    hist_i_d = hist_i_q;
    hist_q_d = hist_q_q;
    seen_d   = seen_q;
    cur_i_d  = cur_i_q;
    cur_q_d  = cur_q_q;
    di_d     = di_q;
    dq_d     = dq_q;
    first_d  = first_q;
    vld_d    = en;
    if (en) begin
      hist_i_d = smp_i;
      hist_q_d = smp_q;
      seen_d   = 1'b1;
      cur_i_d  = smp_i;
      cur_q_d  = smp_q;
      di_d     = DW'(smp_i) - DW'(hist_i_q);
      dq_d     = DW'(smp_q) - DW'(hist_q_q);
      first_d  = ~seen_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_i_q <= '0;
      hist_q_q <= '0;
      seen_q   <= 1'b0;
      cur_i_q  <= '0;
      cur_q_q  <= '0;
      di_q     <= '0;
      dq_q     <= '0;
      vld_q    <= 1'b0;
      first_q  <= 1'b0;
    end else begin
      hist_i_q <= hist_i_d;
      hist_q_q <= hist_q_d;
      seen_q   <= seen_d;
      cur_i_q  <= cur_i_d;
      cur_q_q  <= cur_q_d;
      di_q     <= di_d;
      dq_q     <= dq_d;
      vld_q    <= vld_d;
      first_q  <= first_d;
    end
  end

  assign s1_valid = vld_q;
  assign s1_first = first_q;
  assign s1_i     = cur_i_q;
  assign s1_q     = cur_q_q;
  assign s1_di    = di_q;
  assign s1_dq    = dq_q;
endmodule

// File: rtl/fmd_cross_stage.sv
module fmd_cross_stage #(
  parameter int unsigned W = 16,
  localparam int unsigned DW = W + fmd_pkg::DIFF_EXTRA,
  localparam int unsigned PW = W + DW,
  localparam int unsigned OW = 2 * W + fmd_pkg::OUT_EXTRA
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 s1_valid,
  input  logic                 s1_first,
  input  logic signed [W-1:0]  s1_i,
  input  logic signed [W-1:0]  s1_q,
  input  logic signed [DW-1:0] s1_di,
  input  logic signed [DW-1:0] s1_dq,
  output logic                 o_valid,
  output logic                 o_first,
  output logic signed [OW-1:0] o_value
);
  logic signed [PW-1:0] prod_a, prod_b;
  logic signed [OW-1:0] val_q, val_d;
  logic                 vld_q, vld_d, first_q, first_d;

  always_comb begin
    prod_a  = PW'(s1_i) * PW'(s1_dq);
    prod_b  = PW'(s1_q) * PW'(s1_di);
    val_d   = val_q;
    first_d = first_q;
    vld_d   = s1_valid;
    if (s1_valid) begin
      val_d   = OW'(prod_a) - OW'(prod_b);
      first_d = s1_first;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q   <= '0;
      vld_q   <= 1'b0;
      first_q <= 1'b0;
    end else begin
      val_q   <= val_d;
      vld_q   <= vld_d;
      first_q <= first_d;
    end
  end

  assign o_valid = vld_q;
  assign o_first = first_q & vld_q;
  assign o_value = val_q;
endmodule

// File: rtl/fm_discrim.sv
module fm_discrim #(
  parameter int unsigned W = 16,
  localparam int unsigned DW = W + fmd_pkg::DIFF_EXTRA,
  localparam int unsigned OW = 2 * W + fmd_pkg::OUT_EXTRA
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [W-1:0]  in_i,
  input  logic signed [W-1:0]  in_q,
  output logic                 out_valid,
  output logic                 out_first,
  output logic signed [OW-1:0] out_value
);
  logic                 rst_s_n;
  logic                 s1_valid, s1_first;
  logic signed [W-1:0]  s1_i, s1_q;
  logic signed [DW-1:0] s1_di, s1_dq;

  fmd_rst_sync #(.STAGES(fmd_pkg::SYNC_DEPTH)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  fmd_diff_stage #(.W(W)) u_diff (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .en       (in_valid),
    .smp_i    (in_i),
    .smp_q    (in_q),
    .s1_valid (s1_valid),
    .s1_first (s1_first),
    .s1_i     (s1_i),
    .s1_q     (s1_q),
    .s1_di    (s1_di),
    .s1_dq    (s1_dq)
  );

  fmd_cross_stage #(.W(W)) u_cross (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .s1_valid (s1_valid),
    .s1_first (s1_first),
    .s1_i     (s1_i),
    .s1_q     (s1_q),
    .s1_di    (s1_di),
    .s1_dq    (s1_dq),
    .o_valid  (out_valid),
    .o_first  (out_first),
    .o_value  (out_value)
  );
endmodule

// File: rtl/fm_discrim_chk.sv
module fm_discrim_chk #(
  parameter int unsigned W = 16,
  localparam int unsigned OW = 2 * W + fmd_pkg::OUT_EXTRA
) (
  input logic                 clk,
  input logic                 rst_s_n,
  input logic                 in_valid,
  input logic                 out_valid,
  input logic                 out_first,
  input logic signed [OW-1:0] out_value
);
  // R2: a sample strobe yields a result two cycles later
  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_s_n)
    in_valid |-> ##2 out_valid);
  // R2: no result without a strobe two cycles earlier
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_s_n)
    out_valid |-> $past(in_valid, 2));
  // R4: start-up result is zero
  a_r4_first_zero: assert property (@(posedge clk) disable iff (!rst_s_n)
    out_first |-> (out_value == '0));
  // R5: start-up flag only on a result, and only for one cycle
  a_r5_first_on_valid: assert property (@(posedge clk) disable iff (!rst_s_n)
    out_first |-> out_valid);
  a_r5_first_single: assert property (@(posedge clk) disable iff (!rst_s_n)
    out_first |=> !out_first);
  // R8: result held between strobes
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_s_n)
    !out_valid |-> $stable(out_value));
endmodule

bind fm_discrim fm_discrim_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_s_n   (rst_s_n),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .out_first (out_first),
  .out_value (out_value)
);

// File: tb/fm_discrim_tb_top.sv
module fm_discrim_tb_top;
  localparam int W  = 16;
  localparam int OW = 2 * W + 2;

  logic                 clk;
  logic                 rst_n;
  logic                 in_valid;
  logic signed [W-1:0]  in_i, in_q;
  logic                 out_valid, out_first;
  logic signed [OW-1:0] out_value;

  int checks = 0;
  int errors = 0;
  longint cyc = 0;
  longint m_pi = 0, m_pq = 0;
  bit     m_seen = 0;
  logic [OW-1:0] last_val = '0;

  typedef struct {
    logic [OW-1:0] val;
    bit            first;
    longint        due;
    string         tag;
  } exp_t;
  exp_t q_exp[$];

  fm_discrim #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .out_valid(out_valid), .out_first(out_first), .out_value(out_value)
  );

  initial clk = 0;
  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input logic [OW-1:0] act, input logic [OW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic send(input longint i, input longint q, input string tag);
    exp_t e;
    longint v;
    @(negedge clk);
    in_valid = 1; in_i = W'(i); in_q = W'(q);
    v = i * (q - m_pq) - q * (i - m_pi);
    e.val = OW'(v); e.first = !m_seen; e.due = cyc + 2; e.tag = tag;
    q_exp.push_back(e);
    m_pi = i; m_pq = q; m_seen = 1;
  endtask

  task automatic idle(input int n, input longint gi, input longint gq);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 0; in_i = W'(gi + k); in_q = W'(gq - k);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        if (q_exp.size() == 0) begin
          chk("R2 spurious valid", 1, 0);
        end else begin
          exp_t e;
          e = q_exp.pop_front();
          chk({e.tag, " R3 value"}, out_value, e.val);
          chk({e.tag, " R5 first"}, OW'(out_first), OW'(e.first));
          chk({e.tag, " R2 cycle"}, OW'(cyc), OW'(e.due));
        end
        last_val = out_value;
      end else begin
        chk("R8 hold", out_value, last_val);
      end
    end
  end

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; in_valid = 0; in_i = '0; in_q = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset valid", OW'(out_valid), 0);
    chk("R1 reset first", OW'(out_first), 0);
    chk("R1 reset value", out_value, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1 idle valid", OW'(out_valid), 0);
    // R4, R5: first result after reset is zero and flagged
    send(1234, -567, "R4 first");
    send(1300, -500, "R3 step");
    idle(3, 9999, -9999);
    // R6: ignored words do not alter history
    send(1310, -480, "R6 after gap");
    idle(1, -20000, 20000);
    // rotating phasor, back-to-back (R9)
    for (int k = 0; k < 24; k++) begin
      real ph;
      ph = 0.3 * k;
      send(longint'($rtoi(20000.0 * $cos(ph))), longint'($rtoi(20000.0 * $sin(ph))), "R9 phasor");
    end
    idle(2, 5, 5);
    // R7 full-scale corners
    send(-32768, -32768, "R7 neg");
    send(-32768, 32767, "R7 stepq");
    send(32767, -32768, "R7 stepi");
    send(-32768, -32768, "R7 back");
    send(32767, 32767, "R7 pos");
    send(-32768, 32767, "R7 swing");
    idle(1, 0, 0);
    send(0, 0, "R3 zero");
    send(-1, 1, "R3 small");
    idle(6, 77, 88);
    checks++;
    if (q_exp.size() != 0) begin
      errors++;
      $display("FAIL R2 missing results: actual %0d pending expected 0", q_exp.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule